// File: doc/BRIEF.md
# Serial EEPROM Read Responder

This block stands in for a 64-word, 16-bit serial configuration memory that a host reaches by toggling bits in one control register. The host writes the register to drive four lines: select, serial clock, data toward the memory and data back from it. The block watches each write. A write that raises the clock bit from low to high while the select bit is high moves a small sequencer forward by one bit. The sequencer waits for a start bit, collects a two-bit command code and a six-bit word address, and then presents sixteen data bits on the return-data bit, most significant first.

Only the read command is served, and only three word addresses answer. They return the 48-bit station address supplied on an input port, two bytes per word. Any other command code or address raises a one-cycle error pulse and sends the sequencer back to waiting for a start bit. The host reads the control register back to sample the returned bit.

Control register bits used by the protocol: bit 0 data-in, bit 1 data-out (read-only), bit 2 clock, bit 3 select. Bits above 3 are plain storage.

Top module: `ee_read_responder`

## Requirements
- R1: After reset the control register reads all zeros and the error output is low.
- R2: A host write loads every control register bit from the written value except bit 1, which keeps its previous value; without a write the register does not change.
- R3: The sequencer moves only on a write with bit 3 high whose bit 2 is 1 while the stored bit 2 is 0; writes that keep the clock bit high do not advance it.
- R4: A write with bit 3 low clears bit 0 and returns the sequencer to waiting for a start bit, abandoning any command in progress.
- R5: While waiting, a clock edge with bit 0 low is ignored; a clock edge with bit 0 high begins a command.
- R6: The next two edges collect the command code from bit 0, first bit most significant; code 2'b10 is a read, any other code pulses the error output and returns to waiting.
- R7: The next six edges collect the word address, most significant first. Address 0x0A returns station bytes {5,4}, 0x0B returns {3,2}, 0x0C returns {1,0}, the higher-indexed byte in bits [15:8], byte n being station bits [8n+7:8n]. Any other address pulses the error output and returns to waiting.
- R8: On the edge that completes a served address, bit 0 is cleared; each of the next sixteen edges puts the next data bit, most significant first, on bit 1.
- R9: After the sixteenth data bit the sequencer waits for a new start bit, so a new command may follow without deselecting.
- R10: The error output is high for exactly the one cycle after the offending write.
- R11: The data word is taken from the station input as it stands on the edge that completes the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Control register write strobe |
| host_wdata | input | MGMT_W | Value written to the control register |
| station_addr | input | NSLOT*DATA_W | Station address bytes, byte n at bits [8n+7:8n] |
| host_rdata | output | MGMT_W | Control register contents |
| err_pulse | output | 1 | One-cycle pulse on an unsupported command or address |

## Verification
A wrong bit count or state in the sequencer shows at the ports within one command: the returned word is shifted, the error pulse fires at the wrong edge, or a following command is misread. A wrongly kept clock level shows as a missed or extra step on the very next write. The bench compares the control register and error output against a behavioural model on every cycle, so any divergence is reported in the cycle it appears rather than at the end of a word.

// File: rtl/uwr_pkg.sv
`timescale 1ns/1ps
package uwr_pkg;
  typedef enum logic [1:0] {
    PH_WAIT,
    PH_OPC,
    PH_ADR,
    PH_SHIFT
  } phase_e;

  // control register bit positions (host software decodes these)
  localparam int unsigned BIT_DIN  = 0;
  localparam int unsigned BIT_DOUT = 1;
  localparam int unsigned BIT_SCLK = 2;
  localparam int unsigned BIT_CSEL = 3;
endpackage

// File: rtl/uwr_rst_sync.sv
`timescale 1ns/1ps
module uwr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/uwr_ctl_reg.sv
`timescale 1ns/1ps
module uwr_ctl_reg
  import uwr_pkg::*;
#(
  parameter int unsigned MGMT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MGMT_W-1:0] wr_data,
  input  logic              clr_din,
  input  logic              dout_we,
  input  logic              dout_val,
  output logic [MGMT_W-1:0] ctl_q,
  output logic              step,
  output logic              abort,
  output logic              din_now
);
  logic [MGMT_W-1:0] ctl_d;
  logic              ctl_en;

  // the stored clock bit is the remembered clock level
  assign step    = wr_en & wr_data[BIT_CSEL] & wr_data[BIT_SCLK] & ~ctl_q[BIT_SCLK];
  assign abort   = wr_en & ~wr_data[BIT_CSEL];
  assign din_now = wr_data[BIT_DIN];
  assign ctl_en  = wr_en | clr_din | dout_we;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) begin
      ctl_d           = wr_data;
      ctl_d[BIT_DOUT] = ctl_q[BIT_DOUT];
      if (!wr_data[BIT_CSEL]) ctl_d[BIT_DIN] = 1'b0;
    end
    if (clr_din) ctl_d[BIT_DIN]  = 1'b0;
    if (dout_we) ctl_d[BIT_DOUT] = dout_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end
endmodule

// File: rtl/uwr_word_map.sv
`timescale 1ns/1ps
module uwr_word_map #(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NSLOT    = 3,
  parameter int unsigned BASE_ADR = 10,
  localparam int unsigned STA_W   = NSLOT * DATA_W
) (
  input  logic [STA_W-1:0]  station,
  input  logic [ADDR_W-1:0] adr,
  output logic              hit,
  output logic [DATA_W-1:0] word
);
  logic [NSLOT-1:0]  slot_hit;
  logic [DATA_W-1:0] slot_word [NSLOT];

  // slot k answers BASE_ADR+k with the (NSLOT-1-k)th station word
  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    assign slot_hit[k]  = (adr == ADDR_W'(BASE_ADR + k));
    assign slot_word[k] = station[(NSLOT-1-k)*DATA_W +: DATA_W];
  end

  always_comb begin
    hit  = |slot_hit;
    word = '0;
    for (int k = 0; k < NSLOT; k++) begin
      if (slot_hit[k]) word = word | slot_word[k];
    end
  end
endmodule

// File: rtl/uwr_seq.sv
`timescale 1ns/1ps
module uwr_seq
  import uwr_pkg::*;
#(
  parameter int unsigned OPC_W    = 2,
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned DATA_W   = 16,
  parameter logic [OPC_W-1:0] READ_OPC = 2'b10,
  localparam int unsigned CNT_MAX = (DATA_W > ADDR_W) ?
                                    ((DATA_W > OPC_W) ? DATA_W : OPC_W) :
                                    ((ADDR_W > OPC_W) ? ADDR_W : OPC_W),
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              abort,
  input  logic              din,
  input  logic              word_hit,
  input  logic [DATA_W-1:0] word_val,
  output logic [ADDR_W-1:0] adr_probe,
  output logic              clr_din,
  output logic              dout_we,
  output logic              dout_val,
  output logic              err_o
);
  phase_e            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [OPC_W-1:0]  opc_q, opc_d, opc_nx;
  logic [ADDR_W-1:0] adr_q, adr_d;
  logic [DATA_W-1:0] shf_q, shf_d;
  logic              err_d;
  logic              seq_en;
  logic              last;

  assign opc_nx    = {opc_q[OPC_W-2:0], din};
  assign adr_probe = {adr_q[ADDR_W-2:0], din};
  assign last      = (cnt_q == CNT_W'(1));
  assign seq_en    = step | abort;

  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    opc_d    = opc_q;
    adr_d    = adr_q;
    shf_d    = shf_q;
    err_d    = 1'b0;
    clr_din  = 1'b0;
    dout_we  = 1'b0;
    dout_val = shf_q[DATA_W-1];
    if (abort) begin
      phase_d = PH_WAIT;
      cnt_d   = '0;
    end else if (step) begin
      unique case (phase_q)
        PH_WAIT: begin
          if (din) begin
            phase_d = PH_OPC;
            cnt_d   = CNT_W'(OPC_W);
            opc_d   = '0;
          end
        end
        PH_OPC: begin
          opc_d = opc_nx;
          cnt_d = cnt_q - CNT_W'(1);
          if (last) begin
            if (opc_nx != READ_OPC) begin
              err_d   = 1'b1;
              phase_d = PH_WAIT;
            end else begin
              phase_d = PH_ADR;
              cnt_d   = CNT_W'(ADDR_W);
              adr_d   = '0;
            end
          end
        end
        PH_ADR: begin
          adr_d = adr_probe;
          cnt_d = cnt_q - CNT_W'(1);
          if (last) begin
            if (!word_hit) begin
              err_d   = 1'b1;
              phase_d = PH_WAIT;
            end else begin
              phase_d = PH_SHIFT;
              shf_d   = word_val;
              cnt_d   = CNT_W'(DATA_W);
              clr_din = 1'b1;
            end
          end
        end
        PH_SHIFT: begin
          dout_we = 1'b1;
          shf_d   = {shf_q[DATA_W-2:0], 1'b0};
          cnt_d   = cnt_q - CNT_W'(1);
          if (last) phase_d = PH_WAIT;
        end
        default: phase_d = PH_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_WAIT;
      cnt_q   <= '0;
      opc_q   <= '0;
      adr_q   <= '0;
      shf_q   <= '0;
    end else if (seq_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      opc_q   <= opc_d;
      adr_q   <= adr_d;
      shf_q   <= shf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_o <= 1'b0;
    else        err_o <= err_d;
  end
endmodule

// File: rtl/ee_read_responder.sv
`timescale 1ns/1ps
module ee_read_responder #(
  parameter int unsigned MGMT_W   = 8,
  parameter int unsigned OPC_W    = 2,
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned DATA_W   = 16,
  parameter logic [OPC_W-1:0] READ_OPC = 2'b10,
  parameter int unsigned NSLOT    = 3,
  parameter int unsigned BASE_ADR = 10,
  localparam int unsigned STA_W   = NSLOT * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [MGMT_W-1:0] host_wdata,
  input  logic [STA_W-1:0]  station_addr,
  output logic [MGMT_W-1:0] host_rdata,
  output logic              err_pulse
);
  logic              rst_sync_n;
  logic              step, abort, din_now;
  logic              clr_din, dout_we, dout_val;
  logic              word_hit;
  logic [DATA_W-1:0] word_val;
  logic [ADDR_W-1:0] adr_probe;

  uwr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  uwr_ctl_reg #(.MGMT_W(MGMT_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (host_wr),
    .wr_data  (host_wdata),
    .clr_din  (clr_din),
    .dout_we  (dout_we),
    .dout_val (dout_val),
    .ctl_q    (host_rdata),
    .step     (step),
    .abort    (abort),
    .din_now  (din_now)
  );

  uwr_seq #(
    .OPC_W    (OPC_W),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .READ_OPC (READ_OPC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .step      (step),
    .abort     (abort),
    .din       (din_now),
    .word_hit  (word_hit),
    .word_val  (word_val),
    .adr_probe (adr_probe),
    .clr_din   (clr_din),
    .dout_we   (dout_we),
    .dout_val  (dout_val),
    .err_o     (err_pulse)
  );

  uwr_word_map #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NSLOT    (NSLOT),
    .BASE_ADR (BASE_ADR)
  ) u_map (
    .station (station_addr),
    .adr     (adr_probe),
    .hit     (word_hit),
    .word    (word_val)
  );
endmodule

// File: rtl/ee_read_responder_chk.sv
`timescale 1ns/1ps
module ee_read_responder_chk
  import uwr_pkg::*;
#(
  parameter int unsigned MGMT_W = 8
) (
  input logic              clk,
  input logic              rst_q,
  input logic              host_wr,
  input logic [MGMT_W-1:0] host_wdata,
  input logic [MGMT_W-1:0] host_rdata,
  input logic              err_pulse
);
  logic edge_wr;
  assign edge_wr = host_wr & host_wdata[BIT_CSEL] & host_wdata[BIT_SCLK] & ~host_rdata[BIT_SCLK];

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_q)
    !host_wr |=> $stable(host_rdata));

  assert_write_fields_R2: assert property (@(posedge clk) disable iff (!rst_q)
    host_wr |=> (host_rdata[MGMT_W-1:BIT_SCLK] == $past(host_wdata[MGMT_W-1:BIT_SCLK])));

  assert_dout_hold_R3: assert property (@(posedge clk) disable iff (!rst_q)
    !edge_wr |=> (host_rdata[BIT_DOUT] == $past(host_rdata[BIT_DOUT])));

  assert_deselect_clears_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (host_wr && !host_wdata[BIT_CSEL]) |=> (!host_rdata[BIT_DIN] && !err_pulse));

  assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_q)
    err_pulse |-> $past(edge_wr));

  assert_err_single_R10: assert property (@(posedge clk) disable iff (!rst_q)
    err_pulse |=> !err_pulse);
endmodule

bind ee_read_responder ee_read_responder_chk #(.MGMT_W(MGMT_W)) u_chk (
  .clk        (clk),
  .rst_q      (rst_sync_n),
  .host_wr    (host_wr),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .err_pulse  (err_pulse)
);

// File: tb/ee_read_responder_test.sv
`timescale 1ns/1ps
module ee_read_responder_test;
  localparam logic [7:0] UP = 8'h50;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr;
  logic [7:0]  host_wdata;
  logic [47:0] station;
  logic [7:0]  host_rdata;
  logic        err_pulse;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  ee_read_responder uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr      (host_wr),
    .host_wdata   (host_wdata),
    .station_addr (station),
    .host_rdata   (host_rdata),
    .err_pulse    (err_pulse)
  );

  // behavioural reference model
  logic [7:0]  exp_q;
  logic        exp_err;
  int          phase;
  bit          bits[$];
  int          left;
  logic [15:0] oword;

  always @(posedge clk) begin : ref_model
    logic [7:0] nq;
    int a;
    if (!rst_n) begin
      exp_q = '0; exp_err = 1'b0; phase = 0; left = 0; bits.delete();
    end else begin
      exp_err = 1'b0;
      if (host_wr) begin
        nq = host_wdata;
        nq[1] = exp_q[1];
        if (!host_wdata[3]) begin
          phase = 0; nq[0] = 1'b0; bits.delete();
        end else if (host_wdata[2] && !exp_q[2]) begin
          case (phase)
            0: if (host_wdata[0]) begin phase = 1; bits.delete(); end
            1: begin
              bits.push_back(host_wdata[0]);
              if (bits.size() == 2) begin
                if (bits[0] == 1 && bits[1] == 0) begin phase = 2; bits.delete(); end
                else begin exp_err = 1'b1; phase = 0; end
              end
            end
            2: begin
              bits.push_back(host_wdata[0]);
              if (bits.size() == 6) begin
                a = 0;
                for (int i = 0; i < 6; i++) a = a * 2 + int'(bits[i]);
                phase = 3;
                if (a == 10)      oword = {station[47:40], station[39:32]};
                else if (a == 11) oword = {station[31:24], station[23:16]};
                else if (a == 12) oword = {station[15:8],  station[7:0]};
                else begin exp_err = 1'b1; phase = 0; end
                if (phase == 3) begin left = 16; nq[0] = 1'b0; end
              end
            end
            default: begin
              nq[1] = oword[left-1];
              left = left - 1;
              if (left == 0) phase = 0;
            end
          endcase
        end
        exp_q = nq;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (host_rdata !== exp_q || err_pulse !== exp_err) begin
        errors++;
        $display("FAIL %s: ctl=%h err=%b expected ctl=%h err=%b", tag, host_rdata, err_pulse, exp_q, exp_err);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    host_wr = 1'b1;
    host_wdata = v;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic bitclk(input bit d, output bit dout);
    wr(UP | 8'h08 | {7'd0, d});
    wr(UP | 8'h0C | {7'd0, d});
    dout = host_rdata[1];
  endtask

  task automatic send_cmd(input bit [1:0] opc, input bit [5:0] adr, input int nadr);
    bit x;
    bitclk(1'b1, x);
    for (int i = 1; i >= 0; i--) bitclk(opc[i], x);
    for (int i = 5; i > 5 - nadr; i--) bitclk(adr[i], x);
  endtask

  task automatic shift_bits(input int n, output logic [15:0] w);
    bit d;
    w = '0;
    for (int i = 0; i < n; i++) begin
      bitclk(1'b0, d);
      w = {w[14:0], d};
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] w;
    bit x;
    rst_n = 1'b0; host_wr = 1'b0; host_wdata = '0;
    station = 48'hA1B2_C3D4_E5F6;
    repeat (3) @(negedge clk);
    chk("R1 ctl", {24'd0, host_rdata}, 32'h0);
    chk("R1 err", {31'd0, err_pulse}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    tag = "R2";
    wr(8'hF3);
    chk("R2/R4 deselected write", {24'd0, host_rdata}, 32'hF0);
    wr(8'hAE);
    chk("R2 dout kept, R5 no start", {24'd0, host_rdata}, 32'hAC);
    wr(UP);
    repeat (3) @(negedge clk);
    chk("R2 hold without write", {24'd0, host_rdata}, {24'd0, UP});

    tag = "R7";
    send_cmd(2'b10, 6'h0A, 6);
    shift_bits(16, w);
    chk("R7 word 0x0A", {16'd0, w}, 32'hA1B2);

    tag = "R8";
    send_cmd(2'b10, 6'h0B, 6);
    chk("R8 din cleared", {31'd0, host_rdata[0]}, 32'h0);
    shift_bits(16, w);
    chk("R8 word 0x0B", {16'd0, w}, 32'hC3D4);

    tag = "R9";
    send_cmd(2'b10, 6'h0C, 6);
    shift_bits(16, w);
    chk("R9 back-to-back word 0x0C", {16'd0, w}, 32'hE5F6);

    tag = "R6";
    send_cmd(2'b11, 6'h00, 0);
    chk("R6 opcode 11 error", {31'd0, err_pulse}, 32'h1);
    @(negedge clk);
    chk("R10 error lasts one cycle", {31'd0, err_pulse}, 32'h0);
    send_cmd(2'b00, 6'h00, 0);
    chk("R6 opcode 00 error", {31'd0, err_pulse}, 32'h1);

    tag = "R7";
    send_cmd(2'b10, 6'h05, 6);
    chk("R7 address 0x05 error", {31'd0, err_pulse}, 32'h1);
    send_cmd(2'b10, 6'h0D, 6);
    chk("R7 address 0x0D error", {31'd0, err_pulse}, 32'h1);
    @(negedge clk);
    chk("R10 error cleared", {31'd0, err_pulse}, 32'h0);

    tag = "R11";
    station = 48'h1122_3344_5566;
    send_cmd(2'b10, 6'h0A, 6);
    shift_bits(16, w);
    chk("R11 live station word", {16'd0, w}, 32'h1122);

    tag = "R3";
    wr(UP | 8'h0D);
    wr(UP | 8'h0D);
    wr(UP | 8'h0C);
    bitclk(1'b0, x);
    bitclk(1'b0, x);
    chk("R3/R5 no start without edge", {31'd0, err_pulse}, 32'h0);
    send_cmd(2'b10, 6'h0B, 6);
    shift_bits(16, w);
    chk("R3 read after held clock", {16'd0, w}, 32'h3344);

    tag = "R4";
    send_cmd(2'b10, 6'h0C, 6);
    shift_bits(5, w);
    wr(UP | 8'h01);
    chk("R4 deselect clears din", {31'd0, host_rdata[0]}, 32'h0);
    send_cmd(2'b10, 6'h0C, 6);
    shift_bits(16, w);
    chk("R4 read after abort mid-data", {16'd0, w}, 32'h5566);
    send_cmd(2'b10, 6'h0C, 3);
    wr(UP);
    send_cmd(2'b10, 6'h0A, 6);
    shift_bits(16, w);
    chk("R4 read after abort mid-address", {16'd0, w}, 32'h1122);

    repeat (2) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule